// File: doc/BRIEF.md
# Dual-Mode Character Dot Serializer

This block converts the dots of one character cell from a parallel word into a serial dot stream for a raster display. It has two serial paths. The text path takes a character-generator row pattern and appends a forced blank dot after it, so neighbouring characters are separated by a dark column. The block-graphics path takes six graphic dots and shifts all of them out, so adjacent cells touch with no gap. Both paths use the same six-dot cell period, so a single load strobe per cell drives either mode.

A load takes place only on a dot-clock edge where the active-video qualifier is high and the active-low load strobe is low. While the strobe stays low, the word is reloaded on every edge. Shifting, most significant dot first, starts on the first edge after the strobe returns high. A load into one path clears the other path, so only one of them can ever hold a lit dot. The two serial outputs are combined by OR, and the result is forced dark whenever the active-video qualifier is low.

Top module: `dot_serializer_top`

## Requirements
- R1: A load happens only on a clock edge where `vid_active` is 1 and `load_n` is 0 together. A strobe given while `vid_active` is 0 captures nothing.
- R2: The first dot of a loaded word (its MSB) is on `dot_out` in the cycle after the load edge. While `load_n` stays low the word is reloaded on every edge and the MSB stays on the output. One further dot follows per clock after `load_n` returns high.
- R3: With `gfx_mode` = 1 at the load edge, the six graphic dots go out in order `gfx_bits[5]`, `gfx_bits[4]`, and so on down to `gfx_bits[0]`.
- R4: In graphics mode, loads every six clocks give an unbroken stream. The cycle after `gfx_bits[0]` already shows the next cell's `gfx_bits[5]`.
- R5: With `gfx_mode` = 0 at the load edge, the dots go out as `alpha_bits[4]` down to `alpha_bits[0]`, followed by one dot that is always 0.
- R6: A load in either mode clears the other path, and at most one path drives a 1 at any time.
- R7: While `vid_active` is 0, `dot_out` is 0.
- R8: Once all six dots of a cell have gone out without a reload, `dot_out` stays 0.
- R9: While reset is asserted, and after it is released before any load, `dot_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_n | input | 1 | Active-low cell load strobe |
| vid_active | input | 1 | High while the beam is in the visible area |
| gfx_mode | input | 1 | 1 selects block graphics, 0 selects text |
| alpha_bits | input | 5 | Text row pattern, MSB shown first |
| gfx_bits | input | 6 | Graphic dots, MSB shown first |
| dot_out | output | 1 | Merged serial dot stream |

## Verification
Asymmetric words such as 101101 and 110010 expose a reversed shift order or an off-by-one start. A run of all-ones cells in each mode separates the gapped text path from the gapless graphics path at the cell boundary. Holding the strobe low for several cycles, and letting a cell run past six dots, test the reload and zero-fill behaviour. A cell interrupted by a load in the other mode, a strobe given with video off, and video dropped in the middle of a cell show that the clearing, qualification and blanking work separately from the shift order.

// File: rtl/dot_ser_pkg.sv
package dot_ser_pkg;

  localparam int unsigned CELL_DOTS_DEF = 6;
  localparam int unsigned GAP_DOTS_DEF  = 1;

  typedef enum logic {
    MODE_TEXT = 1'b0,
    MODE_GFX  = 1'b1
  } dot_mode_e;

  typedef struct packed {
    logic ld_text;
    logic ld_gfx;
  } dot_load_t;

endpackage

// File: rtl/dot_rst_sync.sv
module dot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dot_load_ctrl.sv
module dot_load_ctrl
  import dot_ser_pkg::*;
(
  input  logic      load_n,
  input  logic      vid_active,
  input  logic      gfx_mode,
  output dot_load_t load
);

  logic      strobe_ok;
  dot_mode_e mode;

  always_comb begin
    strobe_ok   = vid_active & ~load_n;
    mode        = dot_mode_e'(gfx_mode);
    load.ld_gfx  = strobe_ok & (mode == MODE_GFX);
    load.ld_text = strobe_ok & (mode == MODE_TEXT);
  end

endmodule

// File: rtl/dot_shift_path.sv
module dot_shift_path #(
  parameter int unsigned CELL_DOTS = 6,
  parameter int unsigned DATA_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_own,
  input  logic              load_other,
  input  logic [DATA_W-1:0] data,
  output logic              ser_out
);

  localparam int unsigned PAD_W = CELL_DOTS - DATA_W;

  logic [CELL_DOTS-1:0] word;
  logic [CELL_DOTS-1:0] sh_q;
  logic [CELL_DOTS-1:0] sh_d;
  logic                 sh_en;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {data, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign word = data;
    end
  endgenerate

  always_comb begin
    sh_en = load_own | load_other | (|sh_q);
    if (load_own) begin
      sh_d = word;
    end else if (load_other) begin
      sh_d = '0;
    end else begin
      sh_d = {sh_q[CELL_DOTS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign ser_out = sh_q[CELL_DOTS-1];

endmodule

// File: rtl/dot_merge.sv
module dot_merge (
  input  logic text_dot,
  input  logic gfx_dot,
  input  logic vid_active,
  output logic dot_out
);

  always_comb begin
    dot_out = vid_active & (text_dot | gfx_dot);
  end

endmodule

// File: rtl/dot_serializer_top.sv
module dot_serializer_top
  import dot_ser_pkg::*;
#(
  parameter int unsigned CELL_DOTS = CELL_DOTS_DEF,
  parameter int unsigned GAP_DOTS  = GAP_DOTS_DEF
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load_n,
  input  logic                           vid_active,
  input  logic                           gfx_mode,
  input  logic [CELL_DOTS-GAP_DOTS-1:0]  alpha_bits,
  input  logic [CELL_DOTS-1:0]           gfx_bits,
  output logic                           dot_out
);

  localparam int unsigned TEXT_W = CELL_DOTS - GAP_DOTS;

  logic      rst_int_n;
  dot_load_t load;
  logic      text_dot;
  logic      gfx_dot;

  dot_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dot_load_ctrl u_ctrl (
    .load_n     (load_n),
    .vid_active (vid_active),
    .gfx_mode   (gfx_mode),
    .load       (load)
  );

  dot_shift_path #(.CELL_DOTS(CELL_DOTS), .DATA_W(TEXT_W)) u_text (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_own   (load.ld_text),
    .load_other (load.ld_gfx),
    .data       (alpha_bits),
    .ser_out    (text_dot)
  );

  dot_shift_path #(.CELL_DOTS(CELL_DOTS), .DATA_W(CELL_DOTS)) u_gfx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_own   (load.ld_gfx),
    .load_other (load.ld_text),
    .data       (gfx_bits),
    .ser_out    (gfx_dot)
  );

  dot_merge u_merge (
    .text_dot   (text_dot),
    .gfx_dot    (gfx_dot),
    .vid_active (vid_active),
    .dot_out    (dot_out)
  );

endmodule

// File: rtl/dot_serializer_chk.sv
module dot_serializer_chk #(
  parameter int unsigned CELL_DOTS = 6,
  parameter int unsigned TEXT_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load_n,
  input logic                 vid_active,
  input logic                 gfx_mode,
  input logic [TEXT_W-1:0]    alpha_bits,
  input logic [CELL_DOTS-1:0] gfx_bits,
  input logic                 dot_out,
  input logic                 text_dot,
  input logic                 gfx_dot
);

  logic                 ld_any;
  logic                 armed_text;
  logic                 armed_gfx;
  logic [7:0]           since_ld;
  logic                 last_gfx_dot;

  assign ld_any = vid_active & ~load_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_text   <= 1'b0;
      armed_gfx    <= 1'b0;
      since_ld     <= '0;
      last_gfx_dot <= 1'b0;
    end else if (ld_any) begin
      armed_text   <= ~gfx_mode;
      armed_gfx    <= gfx_mode;
      since_ld     <= '0;
      last_gfx_dot <= gfx_bits[0];
    end else if (since_ld < 8'(CELL_DOTS)) begin
      since_ld <= since_ld + 8'd1;
    end
  end

  assert_text_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_any && !gfx_mode) |=> (!vid_active || dot_out == $past(alpha_bits[TEXT_W-1])));

  assert_gfx_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_any && gfx_mode) |=> (!vid_active || dot_out == $past(gfx_bits[CELL_DOTS-1])));

  assert_text_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_text && since_ld == 8'(CELL_DOTS-1)) |-> !dot_out);

  assert_gfx_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_gfx && since_ld == 8'(CELL_DOTS-1)) |-> (dot_out == (vid_active & last_gfx_dot)));

  assert_one_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({text_dot, gfx_dot}));

  assert_blank_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_active |-> !dot_out);

  assert_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((armed_text || armed_gfx) && since_ld == 8'(CELL_DOTS)) |-> !dot_out);

endmodule

bind dot_serializer_top dot_serializer_chk #(
  .CELL_DOTS (CELL_DOTS),
  .TEXT_W    (CELL_DOTS - GAP_DOTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_n     (load_n),
  .vid_active (vid_active),
  .gfx_mode   (gfx_mode),
  .alpha_bits (alpha_bits),
  .gfx_bits   (gfx_bits),
  .dot_out    (dot_out),
  .text_dot   (text_dot),
  .gfx_dot    (gfx_dot)
);

// File: tb/tb_dot_serializer_top.sv
module tb_dot_serializer_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic       vid_active = 1'b0;
  logic       gfx_mode = 1'b0;
  logic [4:0] alpha_bits = '0;
  logic [5:0] gfx_bits = '0;
  logic       dot_out;

  int checks = 0;
  int failures = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    logic  exp;
    string req;
  } exp_item_t;

  exp_item_t sb_q[$];

  logic [5:0] prev_word = '0;
  int         prev_h = 1;
  int         prev_j = 6;

  dot_serializer_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .vid_active (vid_active),
    .gfx_mode   (gfx_mode),
    .alpha_bits (alpha_bits),
    .gfx_bits   (gfx_bits),
    .dot_out    (dot_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic logic dot_at(logic [5:0] w, int h, int j);
    int idx;
    if (j < h) return w[5];
    idx = 4 - (j - h);
    if (idx < 0) return 1'b0;
    return w[idx];
  endfunction

  task automatic check(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: dot_out=%b expected=%b at cycle %0d", req, act, exp, cyc_cnt);
    end
  endtask

  // One cell: load_n low for h steps, then high for len steps.
  // vid_off marks steps with video off; exp_word is the word the
  // requirements say is captured (text words carry the forced zero LSB).
  task automatic send_cell(logic mode, logic [5:0] data, int h, int len,
                           logic [15:0] vid_off, logic [5:0] exp_word, string req);
    for (int s = 0; s < h + len; s++) begin
      exp_item_t it;
      @(posedge clk);
      #1;
      load_n     = (s < h) ? 1'b0 : 1'b1;
      vid_active = ~vid_off[s];
      gfx_mode   = mode;
      gfx_bits   = data;
      alpha_bits = data[5:1];
      it.cyc = cyc_cnt;
      it.req = req;
      if (s == 0) it.exp = vid_active & dot_at(prev_word, prev_h, prev_j);
      else        it.exp = vid_active & dot_at(exp_word, h, s - 1);
      sb_q.push_back(it);
    end
    prev_word = exp_word;
    prev_h    = h;
    prev_j    = h + len - 1;
  endtask

  // Monitor: samples just before each rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/2 - 1);
      while (sb_q.size() > 0 && sb_q[0].cyc == cyc_cnt) begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(dot_out, it.exp, it.req);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 3000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(dot_out, 1'b0, "R9 in reset");
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 vid_active = 1'b1;
    #2 check(dot_out, 1'b0, "R9 after release");

    // R3 / R4: graphics order and gapless boundaries
    send_cell(1'b1, 6'b101101, 1, 5, 16'h0, 6'b101101, "R3 gfx order");
    send_cell(1'b1, 6'b111111, 1, 5, 16'h0, 6'b111111, "R4 gfx no gap");
    send_cell(1'b1, 6'b100001, 1, 5, 16'h0, 6'b100001, "R4 gfx no gap");
    // R5: text pattern followed by forced blank dot
    send_cell(1'b0, 6'b111111, 1, 5, 16'h0, 6'b111110, "R5 text gap");
    send_cell(1'b0, 6'b111111, 1, 5, 16'h0, 6'b111110, "R5 text gap");
    send_cell(1'b0, 6'b101101, 1, 5, 16'h0, 6'b101100, "R5 text order");
    // R2: strobe held low reloads and holds the MSB
    send_cell(1'b1, 6'b110010, 3, 5, 16'h0, 6'b110010, "R2 held load");
    // R8: cell runs out without reload
    send_cell(1'b1, 6'b100011, 1, 9, 16'h0, 6'b100011, "R8 drain");
    // R6: a load in the other mode clears the running path
    send_cell(1'b0, 6'b111111, 1, 2, 16'h0, 6'b111110, "R6 text cut");
    send_cell(1'b1, 6'b000000, 1, 5, 16'h0, 6'b000000, "R6 text cleared");
    send_cell(1'b1, 6'b111111, 1, 2, 16'h0, 6'b111111, "R6 gfx cut");
    send_cell(1'b0, 6'b000001, 1, 5, 16'h0, 6'b000000, "R6 gfx cleared");
    // R7: video dropped mid-cell
    send_cell(1'b1, 6'b111111, 1, 5, 16'h0018, 6'b111111, "R7 blank");
    send_cell(1'b1, 6'b000000, 1, 6, 16'h0, 6'b000000, "R8 flush");
    // R1: strobe with video off captures nothing
    send_cell(1'b1, 6'b111111, 1, 6, 16'h0001, 6'b000000, "R1 no load");
    send_cell(1'b0, 6'b111111, 1, 6, 16'h0001, 6'b000000, "R1 no load");
    // R1: qualified load after that works
    send_cell(1'b1, 6'b110110, 1, 6, 16'h0, 6'b110110, "R1 load");

    @(posedge clk);
    #1 load_n = 1'b1;
    repeat (3) @(posedge clk);
    if (sb_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule